// File: doc/BRIEF.md
# Serial link break sequencer

This block produces the start-up and reset waveforms for a two-wire serial link. The master owns the serial clock, and the data line can be driven from either end. On request the block walks the serial clock and the data line through a fixed, ordered set of phases. Each phase lasts a set number of serial clock cycles. After the last phase the serial clock rests and the block counts out a settle time in system clock cycles. It then raises a one-cycle completion pulse.

There are two request kinds. An init request clocks out a long run of cycles with data held high, which flushes any stale state in the far end. A break request has four phases: a short high preamble, a forced-low stretch that the far end reads as a reset, a short echo stretch at the idle level, and a long high stretch. The lengths of the low half and the high half of each serial clock cycle come from two inputs, counted in system clock cycles. Both lengths are captured when a request is accepted.

Top module: `lnk_brk_top`

## Requirements
- R1: While reset is asserted, the serial clock and data outputs are 1 and the busy flag, the done pulse and the data output-enable are 0. From the first clock edge after reset is released, the data output-enable stays at 1.
- R2: An init request taken while idle produces INIT_CYC serial clock cycles with data at 1 throughout.
- R3: A break request taken while idle produces PRE_CYC serial cycles with data at 1, then LOW_CYC serial cycles with data at 0, then ECHO_CYC and POST_CYC serial cycles with data at 1. Data is at 0 only during the low stretch.
- R4: Each serial clock cycle is a low half of clk_lo_cyc system cycles followed by a high half of clk_hi_cyc system cycles. The first low half begins in the cycle after the request is sampled.
- R5: A length input of 0 acts as 1.
- R6: After the last serial clock cycle, the serial clock stays at 1 for SETTLE_CYC system cycles. Busy is high for exactly N x (low + high) + SETTLE_CYC cycles, where N is the serial cycle count of the sequence.
- R7: done is 1 for exactly one system cycle: the first cycle with busy at 0 after a sequence. It is 0 at all other times.
- R8: Init and break requests that arrive while busy is 1 are ignored. The running sequence keeps its length and shape.
- R9: When both requests are 1 in the same idle cycle, the break sequence runs.
- R10: While busy is 0, the serial clock and data outputs are both 1.
- R11: The two length inputs are sampled when a request is accepted. Changes to them during a sequence do not affect that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Start an init sequence |
| brk_req | input | 1 | Start a break sequence (wins over init) |
| clk_lo_cyc | input | CW | Serial clock low-half length in system cycles |
| clk_hi_cyc | input | CW | Serial clock high-half length in system cycles |
| scl_o | output | 1 | Serial clock |
| sda_o | output | 1 | Data line output value |
| sda_oe | output | 1 | Data line output-enable |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two of the block's functions can fall in the same system cycle.

- **Both requests in one idle cycle.** Init and break are raised together. The bench judges the winner by counting serial clock falls that see data low: there must be LOW_CYC of them, and the total busy length must match the break sequence.
- **A request arriving mid-sequence.** Both requests are raised, and the low-half length is changed, while a break is already running. The captured waveform must still match the original sequence cycle for cycle in busy length, fall count, low-data falls and first-cycle half lengths.

// File: rtl/lnk_brk_pkg.sv
package lnk_brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_PRE,
        ST_LOW,
        ST_ECHO,
        ST_POST,
        ST_SETTLE
    } seq_st_e;

    // States in which the serial clock runs
    function automatic logic st_clocks(seq_st_e s);
        return (s == ST_INIT) || (s == ST_PRE) || (s == ST_LOW) ||
               (s == ST_ECHO) || (s == ST_POST);
    endfunction

    // Data line level for a state
    function automatic logic st_data(seq_st_e s);
        return (s != ST_LOW);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lnk_brk_div.sv
module lnk_brk_div #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] hi_len,
    output logic          scl,
    output logic          tick
);

    typedef struct packed {
        logic          ph;
        logic [CW-1:0] cnt;
    } div_s;

    div_s div_d, div_q;
    logic [CW-1:0] lim;

    always_comb begin
        div_d = div_q;
        tick  = 1'b0;
        lim   = div_q.ph ? hi_len : lo_len;
        if (!en) begin
            div_d.ph  = 1'b0;
            div_d.cnt = '0;
        end else if (div_q.cnt >= lim - 1'b1) begin
            div_d.cnt = '0;
            div_d.ph  = ~div_q.ph;
            tick      = div_q.ph;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign scl = en ? div_q.ph : 1'b1;

endmodule

// File: rtl/lnk_brk_fsm.sv
module lnk_brk_fsm
    import lnk_brk_pkg::*;
#(
    parameter int INIT_CYC   = 5000,
    parameter int PRE_CYC    = 50,
    parameter int LOW_CYC    = 256,
    parameter int ECHO_CYC   = 16,
    parameter int POST_CYC   = 16000,
    parameter int SETTLE_CYC = 20000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    init_req,
    input  logic    brk_req,
    input  logic    tick,
    output seq_st_e state,
    output logic    start,
    output logic    done
);

    localparam int MAXC  = max_of(max_of(max_of(INIT_CYC, PRE_CYC), max_of(LOW_CYC, ECHO_CYC)),
                                  max_of(POST_CYC, SETTLE_CYC));
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } fsm_s;

    fsm_s fsm_d, fsm_q;
    logic [CNT_W-1:0] lim;
    seq_st_e          nxt;

    // Length of the current phase and the phase that follows it
    always_comb begin
        lim = CNT_W'(1);
        nxt = ST_IDLE;
        case (fsm_q.st)
            ST_INIT:   begin lim = CNT_W'(INIT_CYC);   nxt = ST_SETTLE; end
            ST_PRE:    begin lim = CNT_W'(PRE_CYC);    nxt = ST_LOW;    end
            ST_LOW:    begin lim = CNT_W'(LOW_CYC);    nxt = ST_ECHO;   end
            ST_ECHO:   begin lim = CNT_W'(ECHO_CYC);   nxt = ST_POST;   end
            ST_POST:   begin lim = CNT_W'(POST_CYC);   nxt = ST_SETTLE; end
            ST_SETTLE: begin lim = CNT_W'(SETTLE_CYC); nxt = ST_IDLE;   end
            default:   begin lim = CNT_W'(1);          nxt = ST_IDLE;   end
        endcase
    end

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        start      = 1'b0;
        if (fsm_q.st == ST_IDLE) begin
            fsm_d.cnt = '0;
            if (brk_req) begin
                fsm_d.st = ST_PRE;
                start    = 1'b1;
            end else if (init_req) begin
                fsm_d.st = ST_INIT;
                start    = 1'b1;
            end
        end else if (fsm_q.st == ST_SETTLE) begin
            if (fsm_q.cnt == lim - 1'b1) begin
                fsm_d.st   = nxt;
                fsm_d.cnt  = '0;
                fsm_d.done = 1'b1;
            end else begin
                fsm_d.cnt = fsm_q.cnt + 1'b1;
            end
        end else if (tick) begin
            if (fsm_q.cnt == lim - 1'b1) begin
                fsm_d.st  = nxt;
                fsm_d.cnt = '0;
            end else begin
                fsm_d.cnt = fsm_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, cnt: '0, done: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;
    assign done  = fsm_q.done;

endmodule

// File: rtl/lnk_brk_top.sv
module lnk_brk_top
    import lnk_brk_pkg::*;
#(
    parameter int CW         = 16,
    parameter int INIT_CYC   = 5000,
    parameter int PRE_CYC    = 50,
    parameter int LOW_CYC    = 256,
    parameter int ECHO_CYC   = 16,
    parameter int POST_CYC   = 16000,
    parameter int SETTLE_CYC = 20000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_req,
    input  logic          brk_req,
    input  logic [CW-1:0] clk_lo_cyc,
    input  logic [CW-1:0] clk_hi_cyc,
    output logic          scl_o,
    output logic          sda_o,
    output logic          sda_oe,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
        logic          oe;
    } cfg_s;

    cfg_s    cfg_d, cfg_q;
    seq_st_e state;
    logic    start;
    logic    tick;
    logic    run;

    always_comb begin
        cfg_d    = cfg_q;
        cfg_d.oe = 1'b1;
        if (start) begin
            cfg_d.lo = (clk_lo_cyc == '0) ? CW'(1) : clk_lo_cyc;
            cfg_d.hi = (clk_hi_cyc == '0) ? CW'(1) : clk_hi_cyc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{lo: CW'(1), hi: CW'(1), oe: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run = st_clocks(state);

    lnk_brk_fsm #(
        .INIT_CYC   (INIT_CYC),
        .PRE_CYC    (PRE_CYC),
        .LOW_CYC    (LOW_CYC),
        .ECHO_CYC   (ECHO_CYC),
        .POST_CYC   (POST_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .brk_req  (brk_req),
        .tick     (tick),
        .state    (state),
        .start    (start),
        .done     (done)
    );

    lnk_brk_div #(
        .CW (CW)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (run),
        .lo_len (cfg_q.lo),
        .hi_len (cfg_q.hi),
        .scl    (scl_o),
        .tick   (tick)
    );

    assign sda_o  = st_data(state);
    assign sda_oe = cfg_q.oe;
    assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/lnk_brk_chk.sv
module lnk_brk_chk (
    input logic clk,
    input logic rst_n,
    input logic init_req,
    input logic brk_req,
    input logic scl_o,
    input logic sda_o,
    input logic sda_oe,
    input logic busy,
    input logic done
);

    AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sda_oe); // R1

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o)); // R10

    AST_LOW_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_o |-> busy); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((init_req || brk_req) && !busy) |=> busy); // R2

    AST_SETTLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(scl_o)); // R6

endmodule

bind lnk_brk_top lnk_brk_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .brk_req  (brk_req),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .done     (done)
);

// File: tb/lnk_brk_top_tb.sv
module lnk_brk_top_tb;

    localparam int CW     = 8;
    localparam int INIT_N = 20;
    localparam int PRE_N  = 5;
    localparam int LOW_N  = 8;
    localparam int ECHO_N = 4;
    localparam int POST_N = 12;
    localparam int SET_N  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_req = 1'b0;
    logic          brk_req = 1'b0;
    logic [CW-1:0] clk_lo_cyc = 8'd1;
    logic [CW-1:0] clk_hi_cyc = 8'd1;
    logic          scl_o, sda_o, sda_oe, busy, done;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    lnk_brk_top #(
        .CW (CW), .INIT_CYC (INIT_N), .PRE_CYC (PRE_N), .LOW_CYC (LOW_N),
        .ECHO_CYC (ECHO_N), .POST_CYC (POST_N), .SETTLE_CYC (SET_N)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .init_req (init_req), .brk_req (brk_req),
        .clk_lo_cyc (clk_lo_cyc), .clk_hi_cyc (clk_hi_cyc),
        .scl_o (scl_o), .sda_o (sda_o), .sda_oe (sda_oe), .busy (busy), .done (done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Run one sequence. poke_cyc > 0: at that busy cycle raise both requests and change the low length.
    task automatic run_seq(input string req, input bit do_init, input bit do_brk,
                           input int lo, input int hi, input int poke_cyc);
        int  elo, ehi, n, cyc, falls, low_falls, first_low, lo_run, hi_run, done_busy;
        bit  prev, is_brk;
        elo    = (lo < 1) ? 1 : lo;
        ehi    = (hi < 1) ? 1 : hi;
        is_brk = do_brk;
        n      = is_brk ? (PRE_N + LOW_N + ECHO_N + POST_N) : INIT_N;
        cyc = 0; falls = 0; low_falls = 0; first_low = 0; lo_run = 0; hi_run = 0; done_busy = 0;
        prev = 1'b1;
        @(negedge clk);
        clk_lo_cyc = CW'(lo);
        clk_hi_cyc = CW'(hi);
        init_req   = do_init;
        brk_req    = do_brk;
        @(negedge clk);
        init_req = 1'b0;
        brk_req  = 1'b0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (prev && !scl_o) begin
                falls++;
                if (!sda_o) begin
                    low_falls++;
                    if (first_low == 0) first_low = falls;
                end
            end
            if (falls == 1 && !scl_o) lo_run++;
            if (falls == 1 && scl_o)  hi_run++;
            if (done) done_busy++;
            prev = scl_o;
            if (cyc == poke_cyc) begin
                init_req   = 1'b1;
                brk_req    = 1'b1;
                clk_lo_cyc = 8'd7;
            end
            @(negedge clk);
            init_req = 1'b0;
            brk_req  = 1'b0;
        end
        check(req, "R6 busy length", cyc, n * (elo + ehi) + SET_N);
        check(req, "R2/R3 serial cycle count", falls, n);
        check(req, "R3 falls with data low", low_falls, is_brk ? LOW_N : 0);
        if (is_brk) check(req, "R3 first low cycle index", first_low, PRE_N + 1);
        check(req, "R4/R5 low half length", lo_run, elo);
        check(req, "R4/R5 high half length", hi_run, ehi);
        check(req, "R7 done during busy", done_busy, 0);
        check(req, "R7 done at end", int'(done), 1);
        @(negedge clk);
        check(req, "R7 done one cycle", int'(done), 0);
        check(req, "R10 idle scl", int'(scl_o), 1);
        check(req, "R10 idle sda", int'(sda_o), 1);
        check(req, "R10 idle busy", int'(busy), 0);
    endtask

    task automatic t_reset();
        #2;
        @(negedge clk);
        check("R1", "reset scl", int'(scl_o), 1);
        check("R1", "reset sda", int'(sda_o), 1);
        check("R1", "reset oe", int'(sda_oe), 0);
        check("R1", "reset busy", int'(busy), 0);
        check("R1", "reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "oe after reset", int'(sda_oe), 1);
        check("R10", "idle scl", int'(scl_o), 1);
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        run_seq("R2 init", 1'b1, 1'b0, 1, 1, 0);
        run_seq("R3 break", 1'b0, 1'b1, 2, 3, 0);
        run_seq("R5 zero lengths", 1'b0, 1'b1, 0, 0, 0);
        run_seq("R9 both requests", 1'b1, 1'b1, 1, 2, 0);
        run_seq("R8/R11 poke mid break", 1'b0, 1'b1, 1, 2, 30);
        run_seq("R4 uneven init", 1'b1, 1'b0, 3, 1, 0);
        run_seq("R8 poke mid init", 1'b1, 1'b0, 2, 2, 15);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule